// File: doc/BRIEF.md
# Direct 16-Point DFT Engine

This block turns a block of 16 complex samples into 16 complex frequency bins. It does not use a butterfly network. Each bin is found by multiplying every input sample by a twiddle factor and summing the 16 products. A single shared complex multiply-accumulate unit does all 256 products of a block. Its twiddle factors come from a table of 16 complex roots of unity, and each entry is computed when the design is elaborated.

Samples arrive one at a time on a valid strobe. A start flag marks the first sample of a block. When the sixteenth sample has been captured, the block is copied into a working buffer and the evaluation begins, so the next block can be collected at the same time. Each finished bin is rounded and then shifted out over a one-bit serial link. The link has a per-bit enable and a frame marker. With samples arriving at 64 kHz, one set of bins leaves every 16 samples, which is a 4 kHz block rate.

Top module: `dft16_direct`

## Requirements
- R1: While reset is high, and after it is released, `ser_en`, `ser_data` and `ser_frame` are low until a block has been collected.
- R2: A sample taken with `in_valid` and `in_start` both high is element 0 of a block. Each later sample taken with `in_valid` high fills the next element, up to element 15. Cycles with `in_valid` low are skipped and do not count as samples.
- R3: A sample taken with `in_valid` high and `in_start` low is ignored in two cases: when no start has been seen since reset, and when the current block already holds 16 elements. An ignored sample never starts an output frame.
- R4: Bin k equals the sum over n of x[n]·W^((k·n) mod 16), where W = cos(2π/16) − j·sin(2π/16). Each twiddle component is round(value·2^14), held in 16-bit two's complement, so 1.0 is stored as 16384.
- R5: Each accumulated component a is output as (a + 2^17) >>> 18. This divides by 16 and rounds half up. The result is a 13-bit two's-complement value.
- R6: Bins leave in ascending order from 0 to 15. Each bin sends its 13-bit real part first and then its 13-bit imaginary part, both MSB first, giving 26 bits per bin.
- R7: `ser_frame` is high only while the first bit of bin 0 is on `ser_data`.
- R8: The first bit appears 18 clock cycles after the edge that captured sample 15. `ser_en` is then high for exactly 416 consecutive cycles, and it is low at all other times.
- R9: A new start while a block is partly filled throws away the partial block. Collection restarts at element 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_start | input | 1 | Marks the first sample of a block |
| in_re | input | 12 | Sample real part, two's complement |
| in_im | input | 12 | Sample imaginary part, two's complement |
| ser_en | output | 1 | High while `ser_data` carries a valid bit |
| ser_data | output | 1 | Serial bin data |
| ser_frame | output | 1 | Marks the first bit of bin 0 |

## Verification
The checks assume that a block completes only when the multiply-accumulate unit is idle. They also assume that one output frame has been fully shifted out before the next block's first bin is ready. Under these conditions every burst on `ser_en` is exactly 416 cycles long and opens with the frame marker. The stimulus respects this by leaving more than 450 idle cycles after each completed block before the next one completes. Stray samples, discarded partial blocks and strobes with gaps are all sent inside that spacing. The only thing they change is which block of samples the next frame is computed from.

// File: rtl/dft16_pkg.sv
package dft16_pkg;

    localparam int NPT        = 16;
    localparam int LOG_N      = 4;
    localparam int SMP_W      = 12;
    localparam int TW_FRAC    = 14;
    localparam int TW_W       = TW_FRAC + 2;
    localparam int PROD_W     = SMP_W + TW_W + 1;
    localparam int ACC_W      = PROD_W + LOG_N;
    localparam int OUT_W      = SMP_W + 1;
    localparam int RND_SH     = TW_FRAC + LOG_N;
    localparam int BIN_BITS   = 2 * OUT_W;
    localparam int FRAME_BITS = NPT * BIN_BITS;
    localparam int BCNT_W     = $clog2(BIN_BITS + 1);

    typedef logic [LOG_N-1:0] idx_t;

    typedef struct packed {
        logic signed [SMP_W-1:0] re;
        logic signed [SMP_W-1:0] im;
    } smp_t;

    typedef struct packed {
        logic signed [TW_W-1:0] re;
        logic signed [TW_W-1:0] im;
    } tw_t;

    typedef struct packed {
        logic signed [ACC_W-1:0] re;
        logic signed [ACC_W-1:0] im;
    } acc_t;

    typedef struct packed {
        logic signed [OUT_W-1:0] re;
        logic signed [OUT_W-1:0] im;
    } bin_t;

    // Cosine magnitude for angles 0..4 eighths of a half turn.
    function automatic int quarter_mag(input int q);
        real r;
        case (q)
            0:       r = 1.0;
            1:       r = 0.9238795325112867;
            2:       r = 0.7071067811865476;
            3:       r = 0.3826834323650898;
            default: r = 0.0;
        endcase
        return int'(r * real'(1 << TW_FRAC));
    endfunction

    // Quantised cos(2*pi*m/16) by quarter-wave symmetry.
    function automatic int cos_q(input int m);
        int mm;
        mm = m & (NPT - 1);
        if (mm <= 4)       return quarter_mag(mm);
        else if (mm <= 8)  return -quarter_mag(8 - mm);
        else if (mm <= 12) return -quarter_mag(mm - 8);
        else               return quarter_mag(16 - mm);
    endfunction

    // W^m = cos - j sin; sin(x) = cos(x - pi/2).
    function automatic tw_t twiddle(input int m);
        tw_t t;
        t.re = TW_W'(cos_q(m));
        t.im = TW_W'(-cos_q(m + 12));
        return t;
    endfunction

    // Divide by 16 with round-half-up, truncate to the output width.
    function automatic logic signed [OUT_W-1:0] round_out(input logic signed [ACC_W-1:0] a);
        logic signed [ACC_W:0] ext;
        logic signed [ACC_W:0] sum;
        logic signed [ACC_W:0] shr;
        ext = (ACC_W+1)'(a);
        sum = ext + ((ACC_W+1)'(1) <<< (RND_SH - 1));
        shr = sum >>> RND_SH;
        return shr[OUT_W-1:0];
    endfunction

endpackage

// File: rtl/dft16_collect.sv
module dft16_collect
    import dft16_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_start,
    input  smp_t                 in_smp,
    output smp_t [NPT-1:0]       blk,
    output logic                 blk_go
);

    smp_t [NPT-1:0] cap_q;
    idx_t           wr_idx_q;
    logic           armed_q;
    idx_t           slot;
    logic           accept;

    assign accept = in_valid && (in_start || armed_q);
    assign slot   = in_start ? '0 : wr_idx_q;
    assign blk    = cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            wr_idx_q <= '0;
            blk_go   <= 1'b0;
        end else begin
            blk_go <= 1'b0;
            if (accept) begin
                cap_q[slot] <= in_smp;
                wr_idx_q    <= slot + idx_t'(1);
                if (slot == idx_t'(NPT - 1)) begin
                    armed_q <= 1'b0;
                    blk_go  <= 1'b1;
                end else begin
                    armed_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dft16_twiddle_rom.sv
module dft16_twiddle_rom
    import dft16_pkg::*;
(
    input  idx_t addr,
    output tw_t  tw
);

    tw_t rom [NPT];

    for (genvar g = 0; g < NPT; g++) begin : g_entry
        assign rom[g] = twiddle(g);
    end

    assign tw = rom[addr];

endmodule

// File: rtl/dft16_mac_engine.sv
module dft16_mac_engine
    import dft16_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           blk_go,
    input  smp_t [NPT-1:0] blk,
    input  logic           res_take,
    output logic           busy,
    output bin_t           res,
    output logic           res_valid,
    output logic           res_first
);

    smp_t [NPT-1:0] work_q;
    idx_t           k_q;
    idx_t           n_q;
    acc_t           acc_q;
    acc_t           acc_base;
    acc_t           acc_sum;
    idx_t           tw_addr;
    tw_t            tw;
    smp_t           x;
    logic signed [PROD_W-1:0] p_re;
    logic signed [PROD_W-1:0] p_im;
    logic           last_n;
    logic           stall;
    logic           adv;

    // (k*n) mod 16 falls out of the 4-bit product width.
    assign tw_addr = k_q * n_q;

    dft16_twiddle_rom u_rom (
        .addr (tw_addr),
        .tw   (tw)
    );

    assign x    = work_q[n_q];
    assign p_re = PROD_W'(x.re) * PROD_W'(tw.re) - PROD_W'(x.im) * PROD_W'(tw.im);
    assign p_im = PROD_W'(x.re) * PROD_W'(tw.im) + PROD_W'(x.im) * PROD_W'(tw.re);

    always_comb begin
        acc_base    = (n_q == '0) ? '0 : acc_q;
        acc_sum.re  = acc_base.re + ACC_W'(p_re);
        acc_sum.im  = acc_base.im + ACC_W'(p_im);
    end

    assign last_n = (n_q == idx_t'(NPT - 1));
    assign stall  = last_n && res_valid && !res_take;
    assign adv    = busy && !stall;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            k_q       <= '0;
            n_q       <= '0;
            acc_q     <= '0;
            res       <= '0;
            res_valid <= 1'b0;
            res_first <= 1'b0;
        end else begin
            if (res_take) begin
                res_valid <= 1'b0;
            end
            if (blk_go) begin
                work_q <= blk;
                busy   <= 1'b1;
                k_q    <= '0;
                n_q    <= '0;
            end else if (adv) begin
                acc_q <= acc_sum;
                n_q   <= n_q + idx_t'(1);
                if (last_n) begin
                    res.re    <= round_out(acc_sum.re);
                    res.im    <= round_out(acc_sum.im);
                    res_valid <= 1'b1;
                    res_first <= (k_q == '0);
                    k_q       <= k_q + idx_t'(1);
                    if (k_q == idx_t'(NPT - 1)) begin
                        busy <= 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/dft16_serializer.sv
module dft16_serializer
    import dft16_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  bin_t res,
    input  logic res_valid,
    input  logic res_first,
    output logic res_take,
    output logic ser_en,
    output logic ser_data,
    output logic ser_frame
);

    logic [BIN_BITS-1:0] sh_q;
    logic [BCNT_W-1:0]   left_q;
    logic                frame_q;

    // Reload while the last bit of the previous bin is still on the line.
    assign res_take  = res_valid && (left_q <= BCNT_W'(1));
    assign ser_en    = (left_q != '0);
    assign ser_data  = sh_q[BIN_BITS-1];
    assign ser_frame = frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            left_q  <= '0;
            frame_q <= 1'b0;
        end else if (res_take) begin
            sh_q    <= {res.re, res.im};
            left_q  <= BCNT_W'(BIN_BITS);
            frame_q <= res_first;
        end else if (left_q != '0) begin
            sh_q    <= sh_q << 1;
            left_q  <= left_q - BCNT_W'(1);
            frame_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dft16_direct.sv
module dft16_direct
    import dft16_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    in_start,
    input  logic signed [SMP_W-1:0] in_re,
    input  logic signed [SMP_W-1:0] in_im,
    output logic                    ser_en,
    output logic                    ser_data,
    output logic                    ser_frame
);

    smp_t           in_smp;
    smp_t [NPT-1:0] blk;
    logic           blk_go;
    logic           eng_busy;
    bin_t           res;
    logic           res_valid;
    logic           res_first;
    logic           res_take;

    assign in_smp.re = in_re;
    assign in_smp.im = in_im;

    dft16_collect u_collect (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_start (in_start),
        .in_smp   (in_smp),
        .blk      (blk),
        .blk_go   (blk_go)
    );

    dft16_mac_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .blk_go    (blk_go),
        .blk       (blk),
        .res_take  (res_take),
        .busy      (eng_busy),
        .res       (res),
        .res_valid (res_valid),
        .res_first (res_first)
    );

    dft16_serializer u_ser (
        .clk       (clk),
        .rst       (rst),
        .res       (res),
        .res_valid (res_valid),
        .res_first (res_first),
        .res_take  (res_take),
        .ser_en    (ser_en),
        .ser_data  (ser_data),
        .ser_frame (ser_frame)
    );

endmodule

// File: rtl/dft16_direct_chk.sv
module dft16_direct_chk
    import dft16_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic ser_en,
    input logic ser_frame,
    input logic blk_go,
    input logic eng_busy
);

    localparam int RUN_W = $clog2(FRAME_BITS + 2);
    localparam logic [RUN_W-1:0] BURST_L = RUN_W'(FRAME_BITS);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (ser_en) begin
            run_q <= run_q + RUN_W'(1);
        end else begin
            run_q <= '0;
        end
    end

    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        rst |=> (!ser_en && !ser_frame));

    assert_frame_inside_burst_R7: assert property (@(posedge clk) disable iff (rst)
        ser_frame |-> ser_en);

    assert_burst_opens_with_frame_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_en) |-> ser_frame);

    assert_frame_single_R7: assert property (@(posedge clk) disable iff (rst)
        ser_frame |=> !ser_frame);

    assert_burst_length_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_en) |-> (run_q == BURST_L));

    assert_block_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
        blk_go |-> !eng_busy);

endmodule

bind dft16_direct dft16_direct_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ser_en    (ser_en),
    .ser_frame (ser_frame),
    .blk_go    (blk_go),
    .eng_busy  (eng_busy)
);

// File: tb/dft16_direct_bench.sv
module dft16_direct_bench;
    import dft16_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_start = 1'b0;
    logic signed [SMP_W-1:0] in_re = '0;
    logic signed [SMP_W-1:0] in_im = '0;
    logic ser_en;
    logic ser_data;
    logic ser_frame;

    always #10 clk = ~clk;

    dft16_direct u_dft16_direct (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_start  (in_start),
        .in_re     (in_re),
        .in_im     (in_im),
        .ser_en    (ser_en),
        .ser_data  (ser_data),
        .ser_frame (ser_frame)
    );

    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    chk_on = 1'b0;
    int    exp_start = -100000;
    bit    exp_bit [FRAME_BITS];
    int    blk_re [NPT];
    int    blk_im [NPT];
    string tag = "reset";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] cycle %0d: actual %0d expected %0d", req, tag, cyc, act, expv);
        end
    endtask

    // Reference: direct DFT with independently computed twiddles (R4, R5), packed per R6.
    task automatic build_expect();
        real scale = 2.0 ** TW_FRAC;
        for (int k = 0; k < NPT; k++) begin
            longint ar = 0;
            longint ai = 0;
            longint yr;
            longint yi;
            for (int n = 0; n < NPT; n++) begin
                int  m  = (k * n) % NPT;
                real th = 2.0 * 3.14159265358979323846 * real'(m) / real'(NPT);
                int  wr = int'($cos(th) * scale);
                int  wi = -int'($sin(th) * scale);
                ar += longint'(blk_re[n]) * wr - longint'(blk_im[n]) * wi;
                ai += longint'(blk_re[n]) * wi + longint'(blk_im[n]) * wr;
            end
            yr = (ar + (64'sd1 <<< (RND_SH - 1))) >>> RND_SH;
            yi = (ai + (64'sd1 <<< (RND_SH - 1))) >>> RND_SH;
            for (int b = 0; b < OUT_W; b++) begin
                exp_bit[k*BIN_BITS + b]         = yr[OUT_W-1-b];
                exp_bit[k*BIN_BITS + OUT_W + b] = yi[OUT_W-1-b];
            end
        end
    endtask

    // Cycle-by-cycle comparison of the serial port against the model.
    always @(negedge clk) begin
        int idx;
        if (chk_on) begin
            idx = cyc - exp_start;
            if (idx >= 0 && idx < FRAME_BITS) begin
                check(ser_en == 1'b1, "R8 burst enable", int'(ser_en), 1);
                check(ser_data == exp_bit[idx], "R4 R5 R6 bin data bit", int'(ser_data), int'(exp_bit[idx]));
                check(ser_frame == (idx == 0), "R7 frame marker", int'(ser_frame), int'(idx == 0));
            end else begin
                check(ser_en == 1'b0, "R8 R3 idle enable", int'(ser_en), 0);
                check(ser_frame == 1'b0, "R7 idle frame", int'(ser_frame), 0);
            end
        end
    end

    task automatic send(input int re, input int im, input bit st, input bit last);
        @(negedge clk);
        in_valid = 1'b1;
        in_start = st;
        in_re    = SMP_W'(re);
        in_im    = SMP_W'(im);
        if (last) exp_start = cyc + 19;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_start = 1'b0;
        end
    endtask

    task automatic run_block(input bit gaps);
        build_expect();
        for (int n = 0; n < NPT; n++) begin
            send(blk_re[n], blk_im[n], n == 0, n == NPT - 1);
            if (gaps && (n % 3 == 1)) idle(2);
        end
        idle(460);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs quiet during reset
        check(ser_en == 1'b0, "R1 enable in reset", int'(ser_en), 0);
        check(ser_data == 1'b0, "R1 data in reset", int'(ser_data), 0);
        check(ser_frame == 1'b0, "R1 frame in reset", int'(ser_frame), 0);
        rst = 1'b0;
        chk_on = 1'b1;
        idle(10);

        // R3: stray samples before any start must not produce a frame
        tag = "R3 no start";
        for (int n = 0; n < NPT + 2; n++) send(100 + n, -50, 1'b0, 1'b0);
        idle(60);

        // R2 R4: impulse, back-to-back strobes
        tag = "R2 impulse";
        for (int n = 0; n < NPT; n++) begin blk_re[n] = 0; blk_im[n] = 0; end
        blk_re[0] = 2047;
        run_block(1'b0);

        // R3: extra samples after a full block are ignored
        tag = "R3 after full";
        for (int n = 0; n < NPT; n++) send(-7 * n, 3 * n, 1'b0, 1'b0);
        idle(60);

        // R2: mixed data with gaps in the strobe
        tag = "R2 gaps";
        for (int n = 0; n < NPT; n++) begin
            blk_re[n] = ((n * n * 373 + 91 * n + 17) % 4096) - 2048;
            blk_im[n] = ((n * 1291 + 555) % 4096) - 2048;
        end
        run_block(1'b1);

        // R5: negative full scale on every sample
        tag = "R5 neg full scale";
        for (int n = 0; n < NPT; n++) begin blk_re[n] = -2048; blk_im[n] = -2048; end
        run_block(1'b0);

        // R4 R5: rotating tone concentrated in bin 1
        tag = "R4 tone bin1";
        for (int n = 0; n < NPT; n++) begin
            real th = 2.0 * 3.14159265358979323846 * real'(n) / real'(NPT);
            blk_re[n] = int'(2047.0 * $cos(th));
            blk_im[n] = int'(2047.0 * $sin(th));
        end
        run_block(1'b0);

        // R6: alternating extremes land in bin 8
        tag = "R6 alternating";
        for (int n = 0; n < NPT; n++) begin
            blk_re[n] = (n % 2 == 0) ? 2047 : -2048;
            blk_im[n] = (n % 2 == 0) ? -2048 : 2047;
        end
        run_block(1'b1);

        // R9: partial block discarded by a fresh start
        tag = "R9 restart";
        send(1500, 1500, 1'b1, 1'b0);
        for (int n = 1; n < 8; n++) send(-1500, 900, 1'b0, 1'b0);
        for (int n = 0; n < NPT; n++) begin
            blk_re[n] = 64 * n - 512;
            blk_im[n] = 300 - 40 * n;
        end
        run_block(1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule